// File: doc/BRIEF.md
# Two-Port RAM with Independent Port Widths

This block is a 4,608-bit memory with one write-only port and one read-only port, each on its own clock. Each port picks its own shape through a 2-bit width code. The two shapes are 512 locations of 9 bits and 256 locations of 18 bits. Both shapes view the same storage. A port can therefore write in one shape while the other port reads in the other shape.

The read port offers two latencies, chosen at run time by a pipeline select input. With the select low, data is registered once and appears after the active read edge. With the select high, data passes through a second register and appears one read edge later.

Parameters set the enable polarity and the active clock edge of each port. An asynchronous active-low reset clears the read output registers and blocks every access. It leaves the stored words untouched.

Top module: `dual_aspect_ram`

## Requirements
- R1: While `rstN` is low, `rdData` is all zeros, and it stays zero until the first read after release.
- R2: Width code 2'b01 selects the narrow shape of 512 x 9. A write stores `wrData[8:0]` at the 9-bit `wrAddr`. A read returns that value on `rdData[8:0]`, and `rdData[17:9]` carries no defined value.
- R3: Width code 2'b10 selects the wide shape of 256 x 18. A write stores all 18 bits of `wrData` at `wrAddr[7:0]`. A read returns them on `rdData`.
- R4: The wide word at index a is made of narrow location 2a, which holds bits [8:0], and narrow location 2a+1, which holds bits [17:9]. A write in one shape and a read in the other shape agree on this mapping.
- R5: A narrow write ignores `wrData[17:9]`.
- R6: In the wide shape, address bit 8 is ignored on both ports.
- R7: By default, both enables are active low. A cycle with `wrEn` high stores nothing. A cycle with `rdEn` high leaves `rdData` unchanged.
- R8: Width codes 2'b00 and 2'b11 are reserved. On the write port they store nothing. On the read port they leave `rdData` unchanged.
- R9: With `pipeEn` low, read data appears on `rdData` after the read edge that samples the address and enable.
- R10: With `pipeEn` high, read data appears one read edge later than with `pipeEn` low. Back-to-back reads emerge in order, one per cycle.
- R11: Asserting `rstN` low keeps the stored contents intact. Writes presented while `rstN` is low do not take effect.
- R12: When both ports share one clock, a read and a write to the same location on the same edge return the old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write port clock; active edge set by parameter |
| rdClk | input | 1 | Read port clock; active edge set by parameter |
| rstN | input | 1 | Asynchronous active-low reset of the control and output registers |
| wrEn | input | 1 | Write enable; polarity set by parameter, active low by default |
| wrCode | input | 2 | Write port width code: 01 narrow, 10 wide, others reserved |
| wrAddr | input | 9 | Write address; bit 8 unused in the wide shape |
| wrData | input | 18 | Write data; bits [17:9] unused in the narrow shape |
| rdEn | input | 1 | Read enable; polarity set by parameter, active low by default |
| rdCode | input | 2 | Read port width code: 01 narrow, 10 wide, others reserved |
| rdAddr | input | 9 | Read address; bit 8 unused in the wide shape |
| pipeEn | input | 1 | High selects the two-edge read path, low the one-edge path |
| rdData | output | 18 | Read data |

## Verification
The hardest case to reach is a pipelined read that returns the right word at the right edge. The old data at the end of a one-edge read path would often be the expected value anyway. To rule that out, the bench issues back-to-back pipelined reads of locations that hold distinct values, so a one-edge path would show the wrong word. The same-edge collision case is reached by driving both enables to one address in a single cycle on the shared clock. Retention across reset is shown by attempting a write during reset and then reading the location after release.

// File: rtl/dar_pkg.sv
`timescale 1ns/1ps
package dar_pkg;
  localparam int HALF_W = 9;
  localparam int WORD_W = 2 * HALF_W;
  localparam int ROWS   = 256;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int ADDR_W = ROW_W + 1;

  typedef enum logic [1:0] {
    CODE_RSV_LO = 2'b00,
    CODE_NARROW = 2'b01,
    CODE_WIDE   = 2'b10,
    CODE_RSV_HI = 2'b11
  } widthCode_e;

  typedef struct packed {
    logic [1:0]       halfWe;
    logic             wide;
    logic [ROW_W-1:0] row;
  } wrStrobe_t;

  typedef struct packed {
    logic             fire;
    logic             wide;
    logic             oddHalf;
    logic [ROW_W-1:0] row;
  } rdStrobe_t;
endpackage

// File: rtl/dar_ctrl.sv
`timescale 1ns/1ps
module dar_ctrl
  import dar_pkg::*;
#(
  parameter bit WR_EN_HIGH = 1'b0,
  parameter bit RD_EN_HIGH = 1'b0
) (
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrCode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [1:0]        rdCode,
  input  logic [ADDR_W-1:0] rdAddr,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdStb
);
  logic wrActive, rdActive;
  logic wrNarrow, wrWide, rdNarrow, rdWide;

  assign wrActive = rstN && (wrEn == WR_EN_HIGH);
  assign rdActive = rstN && (rdEn == RD_EN_HIGH);
  assign wrNarrow = (wrCode == CODE_NARROW);
  assign wrWide   = (wrCode == CODE_WIDE);
  assign rdNarrow = (rdCode == CODE_NARROW);
  assign rdWide   = (rdCode == CODE_WIDE);

  always_comb begin
    wrStb = '0;
    wrStb.wide = wrWide;
    if (wrWide) begin
      wrStb.row = wrAddr[ROW_W-1:0];
      if (wrActive) wrStb.halfWe = 2'b11;
    end else begin
      wrStb.row = wrAddr[ADDR_W-1:1];
      if (wrActive && wrNarrow) wrStb.halfWe = wrAddr[0] ? 2'b10 : 2'b01;
    end
  end

  always_comb begin
    rdStb = '0;
    rdStb.fire    = rdActive && (rdNarrow || rdWide);
    rdStb.wide    = rdWide;
    rdStb.oddHalf = rdNarrow && rdAddr[0];
    rdStb.row     = rdWide ? rdAddr[ROW_W-1:0] : rdAddr[ADDR_W-1:1];
  end
endmodule

// File: rtl/dar_datapath.sv
`timescale 1ns/1ps
module dar_datapath
  import dar_pkg::*;
(
  input  logic              wrClkEff,
  input  logic              rdClkEff,
  input  logic              rstN,
  input  logic              pipeEn,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdStb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [HALF_W-1:0] rdHalf [2];
  logic [WORD_W-1:0] stageOne, stageTwo, stageOneNext;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] bank [ROWS];
    logic [HALF_W-1:0] din;
    if (h == 0) begin : g_lo
      assign din = wrData[HALF_W-1:0];
    end else begin : g_hi
      assign din = wrStb.wide ? wrData[WORD_W-1:HALF_W] : wrData[HALF_W-1:0];
    end
    always_ff @(posedge wrClkEff) begin
      if (wrStb.halfWe[h]) bank[wrStb.row] <= din;
    end
    assign rdHalf[h] = bank[rdStb.row];
  end

  always_comb begin
    if (rdStb.wide) stageOneNext = {rdHalf[1], rdHalf[0]};
    else            stageOneNext = {{HALF_W{1'b0}}, rdHalf[rdStb.oddHalf]};
  end

  always_ff @(posedge rdClkEff or negedge rstN) begin
    if (!rstN) begin
      stageOne <= '0;
      stageTwo <= '0;
    end else begin
      if (rdStb.fire) stageOne <= stageOneNext;
      stageTwo <= stageOne;
    end
  end

  assign rdData = pipeEn ? stageTwo : stageOne;
endmodule

// File: rtl/dual_aspect_ram.sv
`timescale 1ns/1ps
module dual_aspect_ram
  import dar_pkg::*;
#(
  parameter bit WR_RISING  = 1'b1,
  parameter bit RD_RISING  = 1'b1,
  parameter bit WR_EN_HIGH = 1'b0,
  parameter bit RD_EN_HIGH = 1'b0
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrCode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [1:0]        rdCode,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              pipeEn,
  output logic [WORD_W-1:0] rdData
);
  wrStrobe_t wrStb;
  rdStrobe_t rdStb;
  logic wrClkEff, rdClkEff;

  if (WR_RISING) begin : g_wr_rise
    assign wrClkEff = wrClk;
  end else begin : g_wr_fall
    assign wrClkEff = ~wrClk;
  end
  if (RD_RISING) begin : g_rd_rise
    assign rdClkEff = rdClk;
  end else begin : g_rd_fall
    assign rdClkEff = ~rdClk;
  end

  dar_ctrl #(.WR_EN_HIGH(WR_EN_HIGH), .RD_EN_HIGH(RD_EN_HIGH)) u_ctrl (
    .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdCode(rdCode), .rdAddr(rdAddr),
    .wrStb(wrStb), .rdStb(rdStb)
  );

  dar_datapath u_dp (
    .wrClkEff(wrClkEff), .rdClkEff(rdClkEff), .rstN(rstN), .pipeEn(pipeEn),
    .wrStb(wrStb), .rdStb(rdStb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dual_aspect_ram_chk.sv
`timescale 1ns/1ps
module dual_aspect_ram_chk
  import dar_pkg::*;
#(
  parameter bit WR_RISING  = 1'b1,
  parameter bit RD_RISING  = 1'b1,
  parameter bit WR_EN_HIGH = 1'b0,
  parameter bit RD_EN_HIGH = 1'b0
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrCode,
  input logic              rdEn,
  input logic [1:0]        rdCode,
  input logic              pipeEn,
  input logic [WORD_W-1:0] rdData,
  input wrStrobe_t         wrStb,
  input rdStrobe_t         rdStb
);
  logic wrE, rdE, rdIdle, wrReserved, wrOn;
  assign wrE = WR_RISING ? wrClk : ~wrClk;
  assign rdE = RD_RISING ? rdClk : ~rdClk;
  assign rdIdle = (rdEn != RD_EN_HIGH) || !(rdCode == CODE_NARROW || rdCode == CODE_WIDE);
  assign wrReserved = !(wrCode == CODE_NARROW || wrCode == CODE_WIDE);
  assign wrOn = (wrEn == WR_EN_HIGH);

  assert_reset_zero_R1: assert property (@(posedge rdE) disable iff (!rstN)
    ($past(rstN) == 1'b0) |-> (rdData == '0));

  assert_narrow_one_half_R2: assert property (@(posedge wrE) disable iff (!rstN)
    (wrOn && wrCode == CODE_NARROW) |-> ($countones(wrStb.halfWe) == 1));

  assert_wide_both_halves_R3: assert property (@(posedge wrE) disable iff (!rstN)
    (wrOn && wrCode == CODE_WIDE) |-> (wrStb.halfWe == 2'b11));

  assert_idle_hold_R7: assert property (@(posedge rdE) disable iff (!rstN)
    (rdIdle && !pipeEn) |=> ($stable(rdData) || pipeEn));

  assert_reserved_no_write_R8: assert property (@(posedge wrE) disable iff (!rstN)
    wrReserved |-> (wrStb.halfWe == 2'b00));

  assert_pipe_hold_R10: assert property (@(posedge rdE) disable iff (!rstN)
    (pipeEn && rdIdle && $past(rdIdle)) |=> (!pipeEn || $stable(rdData)));

  always_comb begin
    if (!rstN) begin
      assert_reset_blocks_write_R11: assert (wrStb.halfWe == 2'b00);
      assert_reset_blocks_read_R11: assert (!rdStb.fire);
    end
  end
endmodule

bind dual_aspect_ram dual_aspect_ram_chk #(
  .WR_RISING(WR_RISING), .RD_RISING(RD_RISING),
  .WR_EN_HIGH(WR_EN_HIGH), .RD_EN_HIGH(RD_EN_HIGH)
) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode),
  .rdEn(rdEn), .rdCode(rdCode), .pipeEn(pipeEn), .rdData(rdData),
  .wrStb(wrStb), .rdStb(rdStb)
);

// File: tb/dual_aspect_ram_test.sv
`timescale 1ns/1ps
module dual_aspect_ram_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, wrEn, rdEn, pipeEn;
  logic [1:0]  wrCode, rdCode;
  logic [8:0]  wrAddr, rdAddr;
  logic [17:0] wrData, rdData;

  dual_aspect_ram uut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode),
    .wrAddr(wrAddr), .wrData(wrData), .rdEn(rdEn), .rdCode(rdCode),
    .rdAddr(rdAddr), .pipeEn(pipeEn), .rdData(rdData)
  );

  typedef struct {
    int          due;
    logic [17:0] exp;
    logic [17:0] mask;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [8:0]  model [512];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [17:0] act,
                       input logic [17:0] exp, input logic [17:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act & mask, exp & mask);
    end
  endtask

  // monitor: pops scoreboard items when their due cycle arrives
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      check(it.tag, rdData, it.exp, it.mask);
    end
  end

  function automatic logic [17:0] expRead(input logic [1:0] code, input logic [8:0] addr);
    if (code == 2'b10) return {model[{addr[7:0], 1'b1}], model[{addr[7:0], 1'b0}]};
    return {9'h000, model[addr]};
  endfunction

  function automatic logic [17:0] maskFor(input logic [1:0] code);
    return (code == 2'b10) ? 18'h3FFFF : 18'h001FF;
  endfunction

  function automatic void modelWrite(input logic [1:0] code, input logic [8:0] addr,
                                     input logic [17:0] data);
    if (code == 2'b01) model[addr] = data[8:0];
    else if (code == 2'b10) begin
      model[{addr[7:0], 1'b0}] = data[8:0];
      model[{addr[7:0], 1'b1}] = data[17:9];
    end
  endfunction

  task automatic wr(input logic [1:0] code, input logic [8:0] addr, input logic [17:0] data);
    wrCode = code; wrAddr = addr; wrData = data; wrEn = 1'b0;
    modelWrite(code, addr, data);
    @(negedge clk);
    wrEn = 1'b1;
  endtask

  task automatic rdCustom(input logic [1:0] code, input logic [8:0] addr, input logic en,
                          input logic [17:0] exp, input logic [17:0] mask, input string tag);
    item_t it;
    rdCode = code; rdAddr = addr; rdEn = en;
    it.due = cyc + (pipeEn ? 2 : 1);
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rdEn = 1'b1;
  endtask

  task automatic rd(input logic [1:0] code, input logic [8:0] addr, input string tag);
    rdCustom(code, addr, 1'b0, expRead(code, addr), maskFor(code), tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wrEn = 1'b1; rdEn = 1'b1; pipeEn = 1'b0;
    wrCode = 2'b01; rdCode = 2'b01; wrAddr = '0; rdAddr = '0; wrData = '0;
    rstN = 1'b1;
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset output", rdData, 18'h0, 18'h3FFFF);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 after release", rdData, 18'h0, 18'h3FFFF);

    // R2 narrow shape, R9 one-edge latency
    wr(2'b01, 9'h003, 18'h000A5);
    wr(2'b01, 9'h000, 18'h0013C);
    wr(2'b01, 9'h1FF, 18'h001C3);
    rd(2'b01, 9'h003, "R2 narrow");
    rd(2'b01, 9'h000, "R9 back-to-back");
    rd(2'b01, 9'h1FF, "R2 top address");

    // R5 narrow write ignores upper data bits
    wr(2'b01, 9'h010, 18'h3FE55);
    wr(2'b01, 9'h011, 18'h154AA);
    rd(2'b10, 9'h008, "R5 upper ignored");

    // R3 wide shape
    wr(2'b10, 9'h020, 18'h25A3C);
    wr(2'b10, 9'h0FF, 18'h1C0DE);
    rd(2'b10, 9'h020, "R3 wide");
    rd(2'b10, 9'h0FF, "R3 wide top");

    // R4 mixed shapes
    wr(2'b10, 9'h030, 18'h1F0F0);
    rd(2'b01, 9'h060, "R4 low half");
    rd(2'b01, 9'h061, "R4 high half");
    wr(2'b01, 9'h070, 18'h00111);
    wr(2'b01, 9'h071, 18'h00122);
    rd(2'b10, 9'h038, "R4 narrow to wide");

    // R6 address bit 8 ignored in wide shape
    wr(2'b10, 9'h141, 18'h31234);
    rd(2'b10, 9'h041, "R6 write bit8");
    rd(2'b10, 9'h141, "R6 read bit8");

    // R7 inactive write enable stores nothing
    wrCode = 2'b01; wrAddr = 9'h003; wrData = 18'h0005A; wrEn = 1'b1;
    @(negedge clk);
    rd(2'b01, 9'h003, "R7 write disabled");
    // R7 inactive read enable holds output
    rd(2'b10, 9'h020, "R7 setup");
    rdCustom(2'b10, 9'h041, 1'b1, expRead(2'b10, 9'h020), 18'h3FFFF, "R7 read disabled");

    // R8 reserved codes
    wrCode = 2'b00; wrAddr = 9'h003; wrData = 18'h000FF; wrEn = 1'b0;
    @(negedge clk);
    wrCode = 2'b11;
    @(negedge clk);
    wrEn = 1'b1;
    rd(2'b01, 9'h003, "R8 reserved write");
    rd(2'b10, 9'h0FF, "R8 setup");
    rdCustom(2'b11, 9'h041, 1'b0, expRead(2'b10, 9'h0FF), 18'h3FFFF, "R8 reserved read 11");
    rdCustom(2'b00, 9'h020, 1'b0, expRead(2'b10, 9'h0FF), 18'h3FFFF, "R8 reserved read 00");

    // R12 same-edge write and read of one location
    begin
      item_t it;
      wrCode = 2'b01; wrAddr = 9'h005; wrData = 18'h00077; wrEn = 1'b0;
      model[9'h005] = 9'h033;
      wr(2'b01, 9'h005, 18'h00033);
      wrCode = 2'b01; wrAddr = 9'h005; wrData = 18'h00077; wrEn = 1'b0;
      rdCode = 2'b01; rdAddr = 9'h005; rdEn = 1'b0;
      it.due = cyc + 1; it.exp = 18'h00033; it.mask = 18'h001FF; it.tag = "R12 old data";
      sb.push_back(it);
      model[9'h005] = 9'h077;
      @(negedge clk);
      wrEn = 1'b1; rdEn = 1'b1;
      rd(2'b01, 9'h005, "R12 new data after");
    end

    // R10 pipelined read
    repeat (3) @(negedge clk);
    pipeEn = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'b10, 9'h020, "R10 pipe first");
    rd(2'b10, 9'h030, "R10 pipe second");
    rd(2'b01, 9'h003, "R10 pipe third");
    rd(2'b10, 9'h141, "R10 pipe fourth");
    repeat (4) @(negedge clk);
    pipeEn = 1'b0;
    repeat (2) @(negedge clk);

    // R11 reset keeps contents and blocks writes
    rstN = 1'b0;
    #1 check("R1 async clear", rdData, 18'h0, 18'h3FFFF);
    @(negedge clk);
    wrCode = 2'b10; wrAddr = 9'h020; wrData = 18'h3FFFF; wrEn = 1'b0;
    rdCode = 2'b10; rdAddr = 9'h020; rdEn = 1'b0;
    @(negedge clk);
    check("R1 read blocked in reset", rdData, 18'h0, 18'h3FFFF);
    wrEn = 1'b1; rdEn = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    rd(2'b10, 9'h020, "R11 retained wide");
    rd(2'b01, 9'h003, "R11 retained narrow");
    repeat (4) @(negedge clk);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule